// File: doc/BRIEF.md
# Periodic Interrupt Timer with Register Interface

This block is a programmable periodic timer that a processor configures and monitors through a small register window on a synchronous read/write bus. A 16-bit down-counter advances on each cycle where the timer tick input is high. When the counter is at zero and a tick arrives, the timer has expired. On expiry it reloads from a software-written modulus and sets a sticky status flag. That flag, gated by an interrupt enable, forms the interrupt request. An 8-bit level value is presented alongside the request.

Software first writes the modulus and the control word, with the timer disabled. It then sets the enable bit, which loads the counter before the first decrement. After expiry the status flag is cleared by writing one to it, and counting carries on with the same period. A debug freeze input can halt counting, but only when the control word permits it. The live count can be read back at any time through a read-only register.

The bus uses byte addresses, and bits [3:2] select a word. Every register keeps its data in the upper half of its 32-bit word, and the lower half reads as zero. Reads are combinational on the address. Writes take effect at the next clock edge.

Top module: `tick_timer_regs`

## Requirements
- R1: After reset every control field, the modulus and the counter are zero, `irq` is 0 and all three registers read 0.
- R2: The control word sits at byte offset 0x0, in bits [31:16]. The level is in bits [31:24], the status flag in bit 23, the interrupt enable in bit 18, the freeze enable in bit 17 and the timer enable in bit 16. All other bits read 0. A write updates the level and the three enables from the same bit positions.
- R3: The modulus sits at offset 0x4, in bits [31:16], and bits [15:0] read 0. Offset 0xC reads 0.
- R4: A control write that changes the enable from 0 to 1 loads the counter from the modulus at that edge. The counter reads at offset 0x8, in bits [31:16], with bits [15:0] reading 0.
- R5: While enabled, each tick that is not frozen decrements a nonzero counter by one, and a cycle without a tick leaves the counter unchanged.
- R6: A counted tick with the counter at zero reloads the modulus and sets the status flag. The period is therefore modulus+1 counted ticks.
- R7: Writing 1 to bit 23 of the control word clears the status flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when both the status flag and the interrupt enable are 1. `irq_level` always shows the level field.
- R9: When freeze enable is 1 and `freeze_in` is high, ticks are not counted. When freeze enable is 0, `freeze_in` has no effect.
- R10: While the timer enable is 0, the counter holds its value and no expiry occurs.
- R11: Writes to offset 0x8 change no state. A new modulus written while running is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address, with bits [3:2] selecting the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Timer clock enable |
| freeze_in | input | 1 | Debug freeze request |
| irq | output | 1 | Interrupt request |
| irq_level | output | 8 | Level tag for the request |

## Verification
Read data depends combinationally on the address and on the current register state. Any write or tick therefore shows up in `bus_rdata`, and in `irq` and `irq_level`, once the next rising edge has passed. This includes reload on expiry, the status update and the load on enable. The bench drives each cycle's inputs just after the falling edge and compares outputs against its model in that same half-cycle, before the rising edge. It then advances the model by exactly one edge. As a result, every expected value is the state that the preceding edge produced. Directed sequences also count the ticks between expiries and pin down clear/expiry collisions and freeze, independently of the per-cycle comparison.

// File: rtl/tick_timer_regs.sv
module tick_timer_regs #(
  parameter int CNT_W  = 16,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              freeze_in,
  output logic              irq,
  output logic [LVL_W-1:0]  irq_level
);
  localparam int HALF   = DATA_W / 2;
  localparam int ST_BIT = HALF + 7;
  localparam int IE_BIT = HALF + 2;
  localparam int FZ_BIT = HALF + 1;
  localparam int EN_BIT = HALF;

  logic [LVL_W-1:0] lvl_q;
  logic             st_q, ie_q, fz_q, en_q;
  logic [CNT_W-1:0] mod_q, cnt_q;

  wire [1:0] word     = bus_addr[3:2];
  wire       ctrl_wr  = bus_wr && word == 2'd0;
  wire       mod_wr   = bus_wr && word == 2'd1;
  wire       start    = ctrl_wr && bus_wdata[EN_BIT] && !en_q;
  wire       run      = en_q && tick && !(fz_q && freeze_in);
  wire       expire   = run && cnt_q == '0;
  wire       clr_req  = ctrl_wr && bus_wdata[ST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      st_q  <= 1'b0;
      ie_q  <= 1'b0;
      fz_q  <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        lvl_q <= bus_wdata[DATA_W-1 -: LVL_W];
        ie_q  <= bus_wdata[IE_BIT];
        fz_q  <= bus_wdata[FZ_BIT];
        en_q  <= bus_wdata[EN_BIT];
      end
      if (expire)       st_q <= 1'b1;
      else if (clr_req) st_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mod_q <= '0;
    else if (mod_wr) mod_q <= bus_wdata[DATA_W-1 -: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= mod_q;
    else if (expire) cnt_q <= mod_q;
    else if (run)    cnt_q <= cnt_q - 1'b1;
  end

  wire [HALF-1:0] ctrl_img = {lvl_q, st_q, 4'b0000, ie_q, fz_q, en_q};

  always_comb begin
    case (word)
      2'd0:    bus_rdata = {ctrl_img, {HALF{1'b0}}};
      2'd1:    bus_rdata = {mod_q, {HALF{1'b0}}};
      2'd2:    bus_rdata = {cnt_q, {HALF{1'b0}}};
      default: bus_rdata = '0;
    endcase
  end

  assign irq       = st_q & ie_q;
  assign irq_level = lvl_q;

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_wr) |=> $stable(cnt_q));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && fz_q && freeze_in) |=> $stable(cnt_q));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (st_q && cnt_q == $past(mod_q)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !st_q);

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (en_q && cnt_q == $past(mod_q)));
endmodule

// File: tb/sim_tick_timer_regs.sv
module sim_tick_timer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0, freeze_in = 1'b0;
  logic        irq;
  logic [7:0]  irq_level;

  always #2.5 clk = ~clk;

  tick_timer_regs u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .freeze_in(freeze_in),
    .irq(irq), .irq_level(irq_level));

  int n_chk = 0, n_bad = 0;
  logic [7:0]  m_lvl;
  logic        m_st, m_ie, m_fz, m_en;
  logic [15:0] m_mod, m_cnt;

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0: return {m_lvl, m_st, 4'b0, m_ie, m_fz, m_en, 16'h0};
      2'd1: return {m_mod, 16'h0};
      2'd2: return {m_cnt, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_expire(input logic tk, input logic fr);
    return m_en && tk && !(m_fz && fr) && m_cnt == 16'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    m_lvl = 0; m_st = 0; m_ie = 0; m_fz = 0; m_en = 0; m_mod = 0; m_cnt = 0;
  endtask

  task automatic model_step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                            input logic tk, input logic fr);
    logic run, ex;
    run = m_en && tk && !(m_fz && fr);
    ex  = run && m_cnt == 16'h0;
    if (wr && a[3:2] == 2'd0 && d[16] && !m_en) m_cnt = m_mod;
    else if (ex)  m_cnt = m_mod;
    else if (run) m_cnt = m_cnt - 16'd1;
    if (ex) m_st = 1'b1;
    else if (wr && a[3:2] == 2'd0 && d[23]) m_st = 1'b0;
    if (wr && a[3:2] == 2'd0) begin
      m_lvl = d[31:24]; m_ie = d[18]; m_fz = d[17]; m_en = d[16];
    end
    if (wr && a[3:2] == 2'd1) m_mod = d[31:16];
  endtask

  task automatic cyc(input string tag, input logic wr, input logic [3:0] a,
                     input logic [31:0] d, input logic tk, input logic fr);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk; freeze_in = fr;
    #1;
    check({tag, " rdata"}, bus_rdata, exp_rd(a));
    check("R8 irq", {31'h0, irq}, {31'h0, m_st & m_ie});
    check("R8 irq_level", {24'h0, irq_level}, {24'h0, m_lvl});
    model_step(wr, a, d, tk, fr);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic [3:0] a, input logic tk);
    cyc(tag, 1'b0, a, 32'h0, tk, 1'b0);
  endtask

  initial begin
    int cyc_cnt;
    cyc_cnt = 0;
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int gaps;
    int last;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state on all offsets
    idle("R1", 4'h0, 1'b0);
    idle("R1", 4'h4, 1'b0);
    idle("R1", 4'h8, 1'b0);
    // R3 modulus and unmapped word
    cyc("R3", 1'b1, 4'h4, 32'h0003_FFFF, 1'b0, 1'b0);
    idle("R3", 4'h4, 1'b0);
    idle("R3", 4'hC, 1'b0);
    // R2 control layout, status not settable by write
    cyc("R2", 1'b1, 4'h0, 32'h0804_FFFF, 1'b1, 1'b0);
    idle("R2", 4'h0, 1'b1);
    idle("R10", 4'h8, 1'b1);
    // R4 enable loads modulus
    cyc("R4", 1'b1, 4'h0, 32'h0805_0000, 1'b0, 1'b0);
    idle("R4", 4'h8, 1'b0);
    idle("R5", 4'h8, 1'b0);
    // R6 period = mod+1 ticks, counted independently
    gaps = 0; last = -1;
    for (int i = 0; i < 12; i++) begin
      if (u0.irq) begin end
      if (irq && last < 0) last = i;
      idle("R6", 4'h8, 1'b1);
    end
    check("R6 first expiry tick count", last, 4);
    // R7 clear with W1C, zero write no change
    cyc("R7", 1'b1, 4'h0, 32'h0805_0000, 1'b0, 1'b0);
    idle("R7", 4'h0, 1'b0);
    check("R7 irq held after zero write", {31'h0, irq}, 32'h1);
    cyc("R7", 1'b1, 4'h0, 32'h0885_0000, 1'b0, 1'b0);
    idle("R7", 4'h0, 1'b0);
    check("R7 irq cleared", {31'h0, irq}, 32'h0);
    // R7 collision: drive ticks until counter is 0 then clear on expiry tick
    for (int i = 0; i < 8 && !(m_cnt == 0 && m_st == 0); i++) idle("R7", 4'h8, 1'b1);
    if (m_st) cyc("R7", 1'b1, 4'h0, 32'h0885_0000, 1'b0, 1'b0);
    while (m_cnt != 0) idle("R7", 4'h8, 1'b1);
    cyc("R7", 1'b1, 4'h0, 32'h0885_0000, 1'b1, 1'b0);
    idle("R7", 4'h0, 1'b0);
    check("R7 collision keeps status", {31'h0, irq}, 32'h1);
    // R9 freeze gated by freeze enable
    cyc("R9", 1'b1, 4'h0, 32'h0887_0000, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc("R9", 1'b0, 4'h8, 32'h0, 1'b1, 1'b1);
    cyc("R9", 1'b1, 4'h0, 32'h0885_0000, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc("R9", 1'b0, 4'h8, 32'h0, 1'b1, 1'b1);
    // R11 writes to count ignored, new modulus at next reload
    cyc("R11", 1'b1, 4'h8, 32'hFFFF_FFFF, 1'b0, 1'b0);
    idle("R11", 4'h8, 1'b0);
    cyc("R11", 1'b1, 4'h4, 32'h0006_0000, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) idle("R11", 4'h8, 1'b1);
    // R10 disable holds
    cyc("R10", 1'b1, 4'h0, 32'h0884_0000, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) idle("R10", 4'h8, 1'b1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [3:0]  a;
      logic [31:0] d;
      w = ($urandom % 8) == 0;
      a = 4'($urandom % 16);
      d = $urandom;
      if (a[3:2] == 2'd1) d[31:16] = 16'($urandom % 8);
      if (a[3:2] == 2'd0 && ($urandom % 4) != 0) d[16] = 1'b1;
      cyc("R5 random", w, a, d, 1'($urandom % 2), ($urandom % 4) == 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule